// File: doc/BRIEF.md
# Prescaled Timer with Compare Units

This block is a general-purpose timer/counter. A free-running prescaler turns the system clock into count enables at one of five fixed ratios. The counter is 8 or 16 bits wide and counts upward. Two compare registers raise match flags. Four counting modes are available. In one of them, a compare A match restarts the counter. The other three wrap the counter at its top value and flag the overflow.

Software sets the timer up through a small register bus: counter, two compare values, two control registers, a flag register and a mask register. A flag whose mask bit is set raises a one-cycle request on its own output while the global enable input is high. The flag is cleared as the request is taken, and the sources are served one per cycle in a fixed priority.

Top module: `prescaled_timer`

## Requirements
- R1: After reset every register reads zero and all three request outputs are low.
- R2: Clock select (control B bits 2:0) codes 1, 2, 3, 4, 5 divide by 1, 8, 64, 256, 1024. After a write that starts the timer from a stopped state, the counter first advances N clocks after the write edge, and then advances every N clocks.
- R3: Clock select codes 0, 6 and 7 stop the counter. While stopped, only a bus write changes it.
- R4: The mode is {control B bit 3, control A bits 1:0}. In modes 0, 1 and 3 the counter wraps from its all-ones value to 0 and sets flag bit 0. In mode 2 a plain wrap sets no flag.
- R5: When the counter takes a value equal to compare A, flag bit 1 is set. When it equals compare B, flag bit 2 is set. A compare register holding zero never matches.
- R6: A bus write to the counter is compared in the same way as a counted step.
- R7: In mode 2, a compare A match loads 0 into the counter and sets flag bits 0 and 1.
- R8: While the global enable is high, the lowest-numbered flag that is also set in the mask drives its request output (bit 0 to the overflow output, bit 1 to compare A, bit 2 to compare B). Only one request is driven per cycle. The served flag is cleared at the next edge. Masked flags raise no request and stay set.
- R9: Register addresses are 0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B, 5 flags, 6 mask, and address 7 reads zero. A write to the flag register replaces its contents. Compare writes take effect at once, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| irq_gie | input | 1 | Global request enable |
| irq_ovf | output | 1 | Overflow request |
| irq_cmpa | output | 1 | Compare A request |
| irq_cmpb | output | 1 | Compare B request |

## Verification
Some behaviours are checked by assertions on every cycle. A stopped counter holds unless it is written. A counted wrap outside mode 2 returns to zero. A clear-on-match lands at zero with the overflow flag set. A compare A flag never rises from a zero compare value. At most one request is driven at a time, and a served flag is gone one cycle later. Other behaviours need the bench's scenarios: the exact divide ratios and first-step latency of each clock-select code, the absence of an overflow flag on a mode 2 wrap, the priority walk through three pending flags, and the register map read-back.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             irq_gie,
  output logic             irq_ovf,
  output logic             irq_cmpa,
  output logic             irq_cmpb
);
  localparam int PRE_W = 10;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [2:0] A_CNT = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                         A_CTLA = 3'd3, A_CTLB = 3'd4, A_FLG = 3'd5, A_MSK = 3'd6;

  logic [CNT_W-1:0] cnt, cmpa, cmpb;
  logic [1:0]       ctla;
  logic [3:0]       ctlb;
  logic [2:0]       flags, mask;
  logic [PRE_W-1:0] pre, pmask;
  logic             running, tick;

  wire [2:0] cs   = ctlb[2:0];
  wire [2:0] mode = {ctlb[3], ctla};

  always_comb begin
    running = 1'b1;
    case (cs)
      3'd1:    pmask = PRE_W'(0);
      3'd2:    pmask = PRE_W'(7);
      3'd3:    pmask = PRE_W'(63);
      3'd4:    pmask = PRE_W'(255);
      3'd5:    pmask = PRE_W'(1023);
      default: begin pmask = '0; running = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !running) pre <= '0;
    else                    pre <= pre + 1'b1;
  end

  assign tick = running && ((pre & pmask) == pmask);

  wire wr_cnt = bus_we && bus_addr == A_CNT;
  wire wr_flg = bus_we && bus_addr == A_FLG;
  wire cnt_chg = wr_cnt || tick;
  wire [CNT_W-1:0] cnt_nv = wr_cnt ? bus_wdata : cnt + 1'b1;
  wire hit_a = cnt_chg && cmpa != '0 && cnt_nv == cmpa;
  wire hit_b = cnt_chg && cmpb != '0 && cnt_nv == cmpb;
  wire ctc_clr = hit_a && mode == 3'd2;
  wire wrap = tick && !wr_cnt && cnt == TOP &&
              (mode == 3'd0 || mode == 3'd1 || mode == 3'd3);
  wire [2:0] evt = {hit_b, hit_a, wrap || ctc_clr};

  wire [2:0] pend  = flags & mask & {3{irq_gie}};
  wire [2:0] serve = pend & (~pend + 3'd1);
  assign {irq_cmpb, irq_cmpa, irq_ovf} = serve;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; cmpa <= '0; cmpb <= '0;
      ctla <= '0; ctlb <= '0; flags <= '0; mask <= '0;
    end else begin
      if (cnt_chg) cnt <= ctc_clr ? '0 : cnt_nv;
      flags <= ((wr_flg ? bus_wdata[2:0] : flags) & ~serve) | evt;
      if (bus_we) begin
        case (bus_addr)
          A_CMPA: cmpa <= bus_wdata;
          A_CMPB: cmpb <= bus_wdata;
          A_CTLA: ctla <= bus_wdata[1:0];
          A_CTLB: ctlb <= bus_wdata[3:0];
          A_MSK:  mask <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmpa;
      A_CMPB:  bus_rdata = cmpb;
      A_CTLA:  bus_rdata = CNT_W'(ctla);
      A_CTLB:  bus_rdata = CNT_W'(ctlb);
      A_FLG:   bus_rdata = CNT_W'(flags);
      A_MSK:   bus_rdata = CNT_W'(mask);
      default: bus_rdata = '0;
    endcase
  end

  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_cnt) |=> $stable(cnt));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt == TOP && !ctc_clr) |=> cnt == '0);
  a_r5_zero_cmp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[1]) && !$past(wr_flg)) |-> $past(cmpa) != '0);
  a_r7_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctc_clr |=> (cnt == '0 && flags[0]));
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_cmpb, irq_cmpa, irq_ovf}));
  a_r8_served_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !evt[0] && !wr_flg) |=> !flags[0]);
endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/100ps
module prescaled_timer_tb_top;
  localparam int W = 8;
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{1, 20, 20}, '{2, 20, 2}, '{2, 24, 3}, '{3, 130, 2}, '{4, 600, 2},
    '{5, 2100, 2}, '{0, 50, 0}, '{6, 50, 0}, '{7, 50, 0}};

  logic clk = 0, rst_n = 0, bus_we = 0, irq_gie = 0;
  logic [2:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  logic irq_ovf, irq_cmpa, irq_cmpb;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  prescaled_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_gie(irq_gie),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1; bus_addr = 3'(a); bus_wdata = W'(d);
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 3'(a);
    #0.2;
    v = int'(bus_rdata);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  int v;

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R1 reg after reset", v, 0);
    end
    chk("R1 irq after reset", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);

    for (int i = 0; i < NV; i++) begin
      wr(4, 0); wr(3, 0); wr(1, 0); wr(2, 0); wr(0, 0);
      wr(4, VEC[i][0]);
      wait_edges(VEC[i][1]);
      rd(0, v);
      chk((VEC[i][0] inside {1,2,3,4,5}) ? "R2 divide" : "R3 stopped", v, VEC[i][2]);
    end

    wr(4, 0); wr(0, 254); wr(5, 0); wr(3, 0); wr(4, 1);
    wait_edges(2);
    rd(0, v); chk("R4 wrap count mode0", v, 0);
    rd(5, v); chk("R4 wrap flag mode0", v, 1);
    wr(4, 0); wr(3, 3); wr(0, 254); wr(5, 0); wr(4, 1);
    wait_edges(2);
    rd(5, v); chk("R4 wrap flag mode3", v, 1);
    wr(4, 0); wr(3, 2); wr(0, 254); wr(5, 0); wr(4, 1);
    wait_edges(2);
    rd(0, v); chk("R4 wrap count mode2", v, 0);
    rd(5, v); chk("R4 no flag mode2 wrap", v, 0);

    wr(4, 0); wr(3, 0); wr(1, 5); wr(2, 0); wr(0, 0); wr(5, 0); wr(4, 1);
    wait_edges(5);
    rd(0, v); chk("R5 count at match", v, 5);
    rd(5, v); chk("R5 flag A only, zero B silent", v, 2);

    wr(4, 0); wr(2, 9); wr(5, 0); wr(0, 9);
    rd(5, v); chk("R6 written count matches B", v, 4);
    rd(0, v); chk("R6 count holds write", v, 9);
    wr(1, 0); wr(5, 0); wr(0, 0);
    rd(5, v); chk("R5 zero compare A never matches", v, 0);

    wr(4, 0); wr(3, 2); wr(1, 4); wr(2, 0); wr(0, 0); wr(5, 0); wr(4, 1);
    wait_edges(4);
    rd(0, v); chk("R7 ctc cleared", v, 0);
    rd(5, v); chk("R7 ctc flags", v, 3);
    wait_edges(2);
    rd(0, v); chk("R7 restart count", v, 2);

    wr(4, 0); wr(3, 0); wr(5, 7); wr(6, 7);
    #0.2;
    chk("R8 no irq without enable", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);
    irq_gie = 1; #0.2;
    chk("R8 overflow first", int'({irq_cmpb, irq_cmpa, irq_ovf}), 1);
    wait_edges(1); #0.2;
    chk("R8 compare A second", int'({irq_cmpb, irq_cmpa, irq_ovf}), 2);
    wait_edges(1); #0.2;
    chk("R8 compare B third", int'({irq_cmpb, irq_cmpa, irq_ovf}), 4);
    wait_edges(1);
    rd(5, v); chk("R8 flags all served", v, 0);
    chk("R8 idle after service", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);
    wr(6, 4); wr(5, 2);
    rd(5, v); chk("R8 masked flag stays", v, 2);
    chk("R8 masked no irq", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);
    irq_gie = 0;

    wr(1, 77); wr(2, 200);
    rd(1, v); chk("R9 compare A readback", v, 77);
    rd(2, v); chk("R9 compare B readback", v, 200);
    rd(6, v); chk("R9 mask readback", v, 4);
    rd(7, v); chk("R9 unused address", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule